// File: doc/BRIEF.md
# Binary-Search Oscillator Frequency Tuner

The block trims the low field of an 18-bit oscillator control word so that the oscillator's edge rate matches a slow reference clock. Edges from the controlled oscillator arrive as `hf_tick` strobes and reference periods arrive as `ref_tick` strobes; both are already synchronized to `clk`. For each trial setting, the tuner counts oscillator edges across a fixed number of reference periods. It compares that count with a host-supplied target and decides one bit of the 7-bit low field, working from the most significant bit down to bit 0. After seven steps it raises `lock`.

The three top code bits are host-writable. The middle bits are a fixed parameter. The search never touches either of them, so the oscillator's coarse range stays where the host put it. Dropping `loop_en` freezes the word at once, and the oscillator frequency then does not step. `force_on` keeps the oscillator enable output asserted whether or not the loop runs.

Top module: `fll_sar_tuner`

## Requirements
- R1: After reset, code[6:0] is 0x40, code[17:15] is HI_INIT (default 2), code[14:7] is MID_INIT (default 0xA5), and lock and busy are 0.
- R2: A search starts in any cycle where loop_en is 1 and either loop_en was 0 in the previous cycle or target differs from its previous-cycle value. From the next cycle, code[6:0] is 0x40, busy is 1 and lock is 0.
- R3: A step closes on the WIN-th ref_tick after the step began (WIN defaults to 4). An hf_tick in that closing cycle is counted. The trial bit stays 1 if the edge count is at most target; otherwise it is cleared.
- R4: Bits are decided in order from bit 6 to bit 0. Closing a step on bit n (n>0) also sets bit n-1 to 1. Closing bit 0 clears busy and sets lock in the same update.
- R5: A search never alters code[17:7].
- R6: While loop_en is 0, no search runs, lock and busy read 0, and code changes only through host writes.
- R7: wr_lo loads wr_data into code[6:0], and wr_hi loads wr_data[2:0] into code[17:15], in the next cycle. Both are ignored in any cycle where a search is running with loop_en high, or where a search starts.
- R8: osc_run is 1 whenever force_on or loop_en is 1, and 0 otherwise.
- R9: If a search start and a host write fall in the same cycle, the start wins and code[6:0] becomes 0x40.
- R10: With a target below any reachable count, the search ends at code[6:0] = 0. With a target above every reachable count, it ends at 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | Enables the tuning loop |
| force_on | input | 1 | Keeps the oscillator enabled |
| target | input | 16 | Wanted oscillator edges per window |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| hf_tick | input | 1 | One-cycle strobe per oscillator edge |
| wr_lo | input | 1 | Host write strobe for code[6:0] |
| wr_hi | input | 1 | Host write strobe for code[17:15] |
| wr_data | input | 7 | Host write data |
| code | output | 18 | Oscillator control word |
| lock | output | 1 | Search finished |
| busy | output | 1 | Search in progress |
| osc_run | output | 1 | Oscillator enable |

## Verification
Two pairs of events can meet in one cycle. A search start can coincide with a host write. An oscillator edge can coincide with the reference tick that closes a window. The bench forces the first pair by raising loop_en in the same cycle as wr_lo, and judges it by whether code[6:0] reads 0x40 afterwards. The second pair comes about naturally: the bench's oscillator model places edges at a rate set by the current code, while the reference tick runs on its own counter. A behavioural model that counts the closing-cycle edge decides every bit, and the code is compared with that model on every clock.

// File: rtl/fll_sar_tuner.sv
module fll_sar_tuner #(
  parameter int CODE_W   = 18,
  parameter int LO_W     = 7,
  parameter int HI_W     = 3,
  parameter int CNT_W    = 16,
  parameter int WIN      = 4,
  parameter int MID_INIT = 8'hA5,
  parameter int HI_INIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic              force_on,
  input  logic [CNT_W-1:0]  target,
  input  logic              ref_tick,
  input  logic              hf_tick,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [LO_W-1:0]   wr_data,
  output logic [CODE_W-1:0] code,
  output logic              lock,
  output logic              busy,
  output logic              osc_run
);
  localparam int MID_W = CODE_W - LO_W - HI_W;
  localparam int IDX_W = $clog2(LO_W);
  localparam int REF_W = $clog2(WIN + 1);
  localparam logic [LO_W-1:0] LO_INIT = LO_W'(1) << (LO_W - 1);

  logic [LO_W-1:0]  lo;
  logic [HI_W-1:0]  hi;
  logic [IDX_W-1:0] idx, idx_m1;
  logic [CNT_W-1:0] cnt, cnt_nx, tgt_q;
  logic [REF_W-1:0] refs;
  logic             en_q, start, run, close, keep;

  assign start   = loop_en && (!en_q || target != tgt_q);
  assign run     = busy && loop_en && !start;
  assign cnt_nx  = cnt + CNT_W'(hf_tick && cnt != '1);
  assign close   = run && ref_tick && refs == REF_W'(WIN - 1);
  assign keep    = cnt_nx <= target;
  assign idx_m1  = idx - 1'b1;
  assign code    = {hi, MID_W'(MID_INIT), lo};
  assign osc_run = force_on | loop_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo    <= LO_INIT;
      hi    <= HI_W'(HI_INIT);
      idx   <= '0;
      cnt   <= '0;
      refs  <= '0;
      tgt_q <= '0;
      en_q  <= 1'b0;
      busy  <= 1'b0;
      lock  <= 1'b0;
    end else begin
      en_q  <= loop_en;
      tgt_q <= target;
      if (!loop_en) begin
        busy <= 1'b0;
        lock <= 1'b0;
      end
      if (start) begin
        busy <= 1'b1;
        lock <= 1'b0;
        lo   <= LO_INIT;
        idx  <= IDX_W'(LO_W - 1);
        cnt  <= '0;
        refs <= '0;
      end else if (run) begin
        cnt <= cnt_nx;
        if (ref_tick) refs <= refs + 1'b1;
        if (close) begin
          lo[idx] <= keep;
          cnt     <= '0;
          refs    <= '0;
          if (idx == '0) begin
            busy <= 1'b0;
            lock <= 1'b1;
          end else begin
            idx        <= idx_m1;
            lo[idx_m1] <= 1'b1;
          end
        end
      end else begin
        if (wr_lo) lo <= wr_data;
        if (wr_hi) hi <= wr_data[HI_W-1:0];
      end
    end
  end

  p_start_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_en) |=> (code[LO_W-1:0] == LO_INIT && busy && !lock));

  p_hold_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && loop_en && !ref_tick && $stable(target) && $stable(loop_en)) |=> $stable(code[LO_W-1:0]));

  p_lock_after_search_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> ($past(busy) && !busy));

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && loop_en) |=> $stable(code[CODE_W-1:LO_W]));

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !wr_lo) |=> ($stable(code[LO_W-1:0]) && !lock && !busy));

  p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    force_on |-> osc_run);
endmodule

// File: tb/test_fll_sar_tuner.sv
module test_fll_sar_tuner;
  localparam int MID = 8'hA5;
  localparam int HIR = 2;
  localparam int WIN = 4;
  localparam int REF_P = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic loop_en = 0, force_on = 0, ref_tick = 0, hf_tick = 0, wr_lo = 0, wr_hi = 0;
  logic [15:0] target = '0;
  logic [6:0]  wr_data = '0;
  logic [17:0] code;
  logic lock, busy, osc_run;

  fll_sar_tuner i_fll_sar_tuner (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .force_on(force_on), .target(target),
    .ref_tick(ref_tick), .hf_tick(hf_tick), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .code(code), .lock(lock), .busy(busy), .osc_run(osc_run));

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, acc = 0, rph = 0;
  bit done = 0;

  int m_lo = 64, m_hi = HIR, m_busy = 0, m_lock = 0, m_idx = 0, m_cnt = 0, m_refs = 0;
  int m_enq = 0, m_tgq = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin : model
      bit st;
      st = loop_en && (m_enq == 0 || int'(target) != m_tgq);
      if (!loop_en) begin m_busy = 0; m_lock = 0; end
      if (st) begin
        m_busy = 1; m_lock = 0; m_lo = 64; m_idx = 6; m_cnt = 0; m_refs = 0;
      end else if (m_busy == 1 && loop_en) begin
        if (hf_tick && m_cnt < 65535) m_cnt++;
        if (ref_tick) m_refs++;
        if (m_refs == WIN) begin
          if (m_cnt > int'(target)) m_lo = m_lo & ~(1 << m_idx);
          m_cnt = 0; m_refs = 0;
          if (m_idx == 0) begin m_busy = 0; m_lock = 1; end
          else begin m_idx--; m_lo = m_lo | (1 << m_idx); end
        end
      end else begin
        if (wr_lo) m_lo = int'(wr_data);
        if (wr_hi) m_hi = int'(wr_data[2:0]);
      end
      m_enq = int'(loop_en);
      m_tgq = int'(target);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin : cmp
      logic [17:0] e;
      e = {m_hi[2:0], MID[7:0], m_lo[6:0]};
      chk(code == e, "R3/R4/R5 code vs model", int'(code), int'(e));
      chk(lock == m_lock[0] && busy == m_busy[0], "R4/R6 lock,busy vs model",
          int'({lock, busy}), int'({m_lock[0], m_busy[0]}));
      chk(osc_run == (force_on | loop_en), "R8 osc_run", int'(osc_run), int'(force_on | loop_en));
    end
    acc = acc + int'(code[6:0]) + 32;
    hf_tick = 0;
    if (acc >= 256) begin acc -= 256; hf_tick = 1; end
    rph = (rph + 1) % REF_P;
    ref_tick = (rph == 0);
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_lock();
    for (int k = 0; k < 3000 && !lock; k++) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk(code == {3'(HIR), 8'(MID), 7'h40} && !lock && !busy, "R1 reset state", int'(code), 'h40);
    rst_n = 1;
    step(2);

    target = 16'd60; loop_en = 1;
    step(2);
    chk(code[6:0] == 7'h40 && busy && !lock, "R2 start at midpoint", int'(code[6:0]), 'h40);
    wait_lock();
    chk(lock == 1'b1, "R4 lock after search", int'(lock), 1);
    chk(code[17:7] == {3'(HIR), 8'(MID)}, "R5 upper bits untouched", int'(code[17:7]), int'({3'(HIR), 8'(MID)}));

    target = 16'd40;
    step(12);
    wr_lo = 1; wr_hi = 1; wr_data = 7'h11;
    step(1);
    wr_lo = 0; wr_hi = 0;
    chk(code[6:0] != 7'h11 && code[17:15] == 3'(HIR), "R7 write ignored in search", int'(code[6:0]), 'h40);
    wait_lock();
    chk(lock == 1'b1, "R2 restart on target change relocks", int'(lock), 1);

    target = 16'd50;
    step(300);
    loop_en = 0;
    step(1);
    begin : frz
      logic [17:0] held;
      held = code;
      step(200);
      chk(code == held && !lock && !busy, "R6 frozen when disabled", int'(code), int'(held));
    end

    wr_lo = 1; wr_hi = 1; wr_data = 7'h15;
    step(1);
    wr_lo = 0; wr_hi = 0;
    chk(code[6:0] == 7'h15 && code[17:15] == 3'd5, "R7 write accepted when idle", int'(code), 'h15);

    force_on = 1; step(1);
    chk(osc_run == 1'b1, "R8 force keeps oscillator on", int'(osc_run), 1);
    force_on = 0; step(1);
    chk(osc_run == 1'b0, "R8 oscillator off", int'(osc_run), 0);

    target = 16'd0; loop_en = 1; wr_lo = 1; wr_data = 7'h2A;
    step(1);
    wr_lo = 0;
    chk(code[6:0] == 7'h40 && busy, "R9 start beats host write", int'(code[6:0]), 'h40);
    wait_lock();
    chk(code[6:0] == 7'h00 && lock, "R10 low target gives zero", int'(code[6:0]), 0);

    target = 16'd1000;
    step(2);
    wait_lock();
    chk(code[6:0] == 7'h7F && lock, "R10 high target gives all ones", int'(code[6:0]), 'h7F);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule